// File: doc/BRIEF.md
# Paged Monochrome Frame Buffer Controller

This block stores the image for a 128 by 64 pixel display with one bit per pixel. A processor drives it through three word-wide write registers. A control register selects the access mode. Two magic words pick data mode and command mode. Any other word leaves the block in an invalid mode.

Set-page instructions choose one of eight bands, each eight rows tall. They arrive either at the instruction register or, in command mode, at the data register. In data mode each byte written to the data register is a vertical strip of eight pixels. It is placed at the current page and column, and the column then steps forward, wrapping inside the page.

A separate read port serves a raster scanner. It takes a pixel coordinate and returns, one clock later, the pixel's colour as three 8-bit channels. The colour is scaled by a 3-bit brightness level.

Top module: `lcd_fb`

## Requirements
- R1: After reset every stored pixel is clear, the column and page are 0, the mode is invalid, and the colour outputs read 0.
- R2: A write to offset 0x1AC selects the mode. The word 0x00100011 gives data mode, 0x00104011 gives command mode, and any other word gives invalid mode. In invalid mode a data-register write stores nothing and leaves the column unchanged.
- R3: A write to offset 0x1BC whose word lies in 0xB0..0xB7 sets the page to word minus 0xB0 and the column to 0. Any other word at this offset changes nothing.
- R4: In command mode, a data-register write (offset 0x1C0) with a word in 0xB0..0xB7 acts as in R3. Any data-register write in command mode stores nothing.
- R5: In data mode, a data-register write stores bits 7:0 of the word at byte address page*128 + column. The column then becomes (column+1) mod 128, and the page stays the same.
- R6: The pixel at (x, y) is bit (y mod 8) of byte x + (y div 8)*128.
- R7: A set pixel is shown in the base colour R=0xE0, G=0xE0, B=0xFF, scaled as in R8. A clear pixel gives 0 on all channels.
- R8: With brightness level L (0..7), each channel of a set pixel is floor(base*L/7). L=0 gives black and L=7 gives the base colour.
- R9: The colour outputs show the pixel and level presented at the previous rising edge. When a data write to the same byte happens at that edge, the outputs show the byte as it was before the write.
- R10: Writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write word |
| level | input | 3 | Brightness level 0..7 |
| pix_x | input | 7 | Requested pixel column |
| pix_y | input | 6 | Requested pixel row |
| pix_r | output | 8 | Red channel of requested pixel |
| pix_g | output | 8 | Green channel of requested pixel |
| pix_b | output | 8 | Blue channel of requested pixel |

## Verification
A data-register store and a scanner read of the same byte can land on the same rising edge. The bench provokes this by presenting the store and the read coordinate in the same cycle. It expects the pre-write colour one clock later and the new colour on the request that follows.

The bench keeps its own byte image and mode, page and column model, built from the requirements. It compares every pixel at several brightness levels, including after a column wrap and after the writes that must be ignored.

// File: rtl/lcd_fb_pkg.sv
package lcd_fb_pkg;
   typedef enum logic [1:0] {
      MODE_INVALID = 2'd0,
      MODE_DATA    = 2'd1,
      MODE_CMD     = 2'd2
   } lcd_mode_e;
endpackage

// File: rtl/lcd_fb_ctrl.sv
module lcd_fb_ctrl
   import lcd_fb_pkg::*;
#(
   parameter int COLS          = 128,
   parameter int PAGES         = 8,
   parameter int BUS_AW        = 12,
   parameter int BUS_DW        = 32,
   parameter int OFS_MODE      = 'h1AC,
   parameter int OFS_INSTR     = 'h1BC,
   parameter int OFS_DATA      = 'h1C0,
   parameter logic [31:0] WORD_DATA = 32'h0010_0011,
   parameter logic [31:0] WORD_CMD  = 32'h0010_4011,
   parameter int PAGE_OP_BASE  = 'hB0,
   localparam int CW = $clog2(COLS),
   localparam int PW = $clog2(PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic              mem_we,
   output logic [PW+CW-1:0]  mem_addr,
   output logic [7:0]        mem_data
);
   lcd_mode_e      mode_q;
   logic [PW-1:0]  page_q;
   logic [CW-1:0]  col_q;

   logic           hit_mode, hit_instr, hit_data, in_range, page_load, store;
   logic [PW-1:0]  new_page;

   if ((COLS & (COLS - 1)) != 0 || (PAGES & (PAGES - 1)) != 0) begin : g_bad_geom
      $error("lcd_fb_ctrl: COLS and PAGES must be powers of two");
   end

   assign hit_mode  = bus_we && (bus_addr == BUS_AW'(OFS_MODE));
   assign hit_instr = bus_we && (bus_addr == BUS_AW'(OFS_INSTR));
   assign hit_data  = bus_we && (bus_addr == BUS_AW'(OFS_DATA));
   assign in_range  = (bus_wdata >= BUS_DW'(PAGE_OP_BASE)) &&
                      (bus_wdata <  BUS_DW'(PAGE_OP_BASE + PAGES));
   assign new_page  = PW'(bus_wdata - BUS_DW'(PAGE_OP_BASE));
   assign page_load = in_range && (hit_instr || (hit_data && mode_q == MODE_CMD));
   assign store     = hit_data && (mode_q == MODE_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_INVALID;
         page_q <= '0;
         col_q  <= '0;
      end else begin
         if (hit_mode) begin
            if (bus_wdata == BUS_DW'(WORD_DATA))     mode_q <= MODE_DATA;
            else if (bus_wdata == BUS_DW'(WORD_CMD)) mode_q <= MODE_CMD;
            else                                      mode_q <= MODE_INVALID;
         end
         if (page_load) begin
            page_q <= new_page;
            col_q  <= '0;
         end else if (store) begin
            col_q  <= col_q + 1'b1;
         end
      end
   end

   assign mem_we   = store;
   assign mem_addr = {page_q, col_q};
   assign mem_data = bus_wdata[7:0];

   a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> col_q == CW'($past(col_q) + 1'b1));
   a_r3_page_load: assert property (@(posedge clk) disable iff (!rst_n)
      page_load |=> (page_q == $past(new_page)) && (col_q == '0));
   a_r2_pointer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!store && !page_load) |=> $stable(col_q) && $stable(page_q));
   a_r2_invalid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_INVALID && !hit_mode) |=> mode_q == MODE_INVALID);
endmodule

// File: rtl/lcd_fb_vram.sv
module lcd_fb_vram #(
   parameter int DEPTH = 1024,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/lcd_fb_shade.sv
module lcd_fb_shade #(
   parameter int CHW    = 8,
   parameter int LEVELS = 8,
   parameter logic [3*CHW-1:0] COLOUR = 24'hE0E0FF,
   localparam int LW = $clog2(LEVELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_on,
   input  logic [LW-1:0]    level,
   output logic [3*CHW-1:0] rgb
);
   if (LEVELS < 2 || (LEVELS & (LEVELS - 1)) != 0) begin : g_bad_levels
      $error("lcd_fb_shade: LEVELS must be a power of two of at least 2");
   end

   for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      localparam logic [CHW-1:0] BASE = COLOUR[ch*CHW +: CHW];
      logic [CHW+LW-1:0] prod;
      logic [CHW-1:0]    scaled, chan_q;

      assign prod   = (CHW+LW)'(BASE) * (CHW+LW)'(level);
      assign scaled = CHW'(prod / (CHW+LW)'(LEVELS - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chan_q <= '0;
         else if (pix_on) chan_q <= scaled;
         else             chan_q <= '0;
      end

      assign rgb[ch*CHW +: CHW] = chan_q;
   end

   a_r7_clear_black: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !pix_on) |-> rgb == '0);
   a_r8_full_level: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && pix_on && level == LW'(LEVELS - 1)) |-> rgb == COLOUR);
   a_r8_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && level == '0) |-> rgb == '0);
endmodule

// File: rtl/lcd_fb.sv
module lcd_fb #(
   parameter int COLS   = 128,
   parameter int ROWS   = 64,
   parameter int CHW    = 8,
   parameter int LEVELS = 8,
   parameter int BUS_AW = 12,
   parameter int BUS_DW = 32,
   parameter logic [3*CHW-1:0] COLOUR = 24'hE0E0FF,
   localparam int PAGES = ROWS / 8,
   localparam int DEPTH = COLS * PAGES,
   localparam int AW    = $clog2(DEPTH),
   localparam int XW    = $clog2(COLS),
   localparam int YW    = $clog2(ROWS),
   localparam int LW    = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   input  logic [LW-1:0]     level,
   input  logic [XW-1:0]     pix_x,
   input  logic [YW-1:0]     pix_y,
   output logic [CHW-1:0]    pix_r,
   output logic [CHW-1:0]    pix_g,
   output logic [CHW-1:0]    pix_b
);
   if (ROWS % 8 != 0 || ROWS < 16) begin : g_bad_rows
      $error("lcd_fb: ROWS must be a multiple of 8 and at least 16");
   end

   logic          mem_we;
   logic [AW-1:0] mem_addr, rd_addr;
   logic [7:0]    mem_data, rd_byte;
   logic [3*CHW-1:0] rgb;

   lcd_fb_ctrl #(
      .COLS(COLS), .PAGES(PAGES), .BUS_AW(BUS_AW), .BUS_DW(BUS_DW)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_data(mem_data)
   );

   lcd_fb_vram #(.DEPTH(DEPTH)) u_vram (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr),
      .wdata(mem_data), .raddr(rd_addr), .rdata(rd_byte)
   );

   assign rd_addr = {pix_y[YW-1:3], pix_x};

   lcd_fb_shade #(.CHW(CHW), .LEVELS(LEVELS), .COLOUR(COLOUR)) u_shade (
      .clk(clk), .rst_n(rst_n), .pix_on(rd_byte[pix_y[2:0]]),
      .level(level), .rgb(rgb)
   );

   assign pix_r = rgb[2*CHW +: CHW];
   assign pix_g = rgb[CHW +: CHW];
   assign pix_b = rgb[0 +: CHW];
endmodule

// File: tb/sim_lcd_fb.sv
`timescale 1ns/1ps
module sim_lcd_fb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [2:0]  level = '0;
   logic [6:0]  pix_x = '0;
   logic [5:0]  pix_y = '0;
   logic [7:0]  pix_r, pix_g, pix_b;

   int checks = 0;
   int errors = 0;

   logic [7:0] sh [1024];
   int m_mode = 0;
   int m_page = 0;
   int m_col = 0;

   always #2 clk = ~clk;

   lcd_fb u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .level(level), .pix_x(pix_x), .pix_y(pix_y),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
   );

   function automatic logic [23:0] exp_rgb(bit on, int lvl);
      if (!on) return 24'h0;
      return {8'((224 * lvl) / 7), 8'((224 * lvl) / 7), 8'((255 * lvl) / 7)};
   endfunction

   function automatic bit model_pix(int x, int y);
      return sh[x + (y / 8) * 128][y % 8];
   endfunction

   task automatic model_write(int addr, logic [31:0] d);
      bit rng = (d >= 32'hB0) && (d <= 32'hB7);
      if (addr == 'h1AC) begin
         m_mode = (d == 32'h0010_0011) ? 1 : (d == 32'h0010_4011) ? 2 : 0;
      end else if (addr == 'h1BC) begin
         if (rng) begin m_page = int'(d) - 'hB0; m_col = 0; end
      end else if (addr == 'h1C0) begin
         if (m_mode == 2 && rng) begin
            m_page = int'(d) - 'hB0; m_col = 0;
         end else if (m_mode == 1) begin
            sh[m_page * 128 + m_col] = d[7:0];
            m_col = (m_col + 1) % 128;
         end
      end
   endtask

   task automatic wr(int addr, logic [31:0] d);
      bus_we = 1'b1; bus_addr = 12'(addr); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      model_write(addr, d);
   endtask

   task automatic expect_rgb(logic [23:0] exp, string tag);
      logic [23:0] got = {pix_r, pix_g, pix_b};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s x=%0d y=%0d lvl=%0d got %06h exp %06h",
                  tag, pix_x, pix_y, level, got, exp);
      end
   endtask

   task automatic chk_pix(int x, int y, int lvl, string tag);
      logic [23:0] exp;
      pix_x = 7'(x); pix_y = 6'(y); level = 3'(lvl);
      exp = exp_rgb(model_pix(x, y), lvl);
      @(negedge clk);
      expect_rgb(exp, tag);
   endtask

   task automatic sweep(int lvl_ofs, string tag);
      for (int y = 0; y < 64; y++)
         for (int x = 0; x < 128; x++)
            chk_pix(x, y, (x + y + lvl_ofs) % 8, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [23:0] old_exp;
      for (int i = 0; i < 1024; i++) sh[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1: outputs zero while and right after reset
      expect_rgb(24'h0, "R1 reset outputs");
      rst_n = 1'b1;
      @(negedge clk);
      expect_rgb(24'h0, "R1 after release");
      for (int y = 0; y < 64; y++)
         for (int x = 0; x < 128; x++)
            chk_pix(x, y, 7, "R1 cleared image");

      // R2: invalid mode after reset ignores data writes
      wr('h1C0, 32'hFF);
      chk_pix(0, 0, 7, "R2 invalid store ignored");
      chk_pix(1, 0, 7, "R2 invalid store ignored");
      wr('h1AC, 32'h0010_0011);
      wr('h1C0, 32'h81);
      chk_pix(0, 0, 7, "R2 column unchanged in invalid mode");
      chk_pix(0, 7, 7, "R2 column unchanged in invalid mode");
      chk_pix(1, 0, 7, "R5 single store");

      // R3 + R5: page select and column wrap within the page
      wr('h1BC, 32'hB3);
      for (int i = 0; i < 130; i++) wr('h1C0, 32'((i * 7 + 1) & 'hFF) | 32'hA500);
      for (int b = 0; b < 8; b++) begin
         chk_pix(0, 24 + b, 7, "R5 wrap overwrote column 0");
         chk_pix(1, 24 + b, 5, "R5 wrap overwrote column 1");
         chk_pix(127, 24 + b, 7, "R5 last column of page");
         chk_pix(0, 32 + b, 7, "R5 page unchanged by wrap");
      end

      // R4: command mode page select through data register, no store
      wr('h1AC, 32'h0010_4011);
      wr('h1C0, 32'hB5);
      wr('h1C0, 32'h5A);
      wr('h1AC, 32'h0010_0011);
      wr('h1C0, 32'h3C);
      for (int b = 0; b < 8; b++) chk_pix(0, 40 + b, 7, "R4 command page select");
      chk_pix(2, 24, 7, "R4 command write stored nothing");

      // R3: out-of-range instruction words change nothing
      wr('h1BC, 32'hB8);
      wr('h1BC, 32'hAF);
      wr('h1BC, 32'h1B2);
      wr('h1C0, 32'hC3);
      for (int b = 0; b < 8; b++) chk_pix(1, 40 + b, 7, "R3 bad instruction ignored");

      // R2: non-magic mode word gives invalid mode
      wr('h1AC, 32'h0010_0010);
      wr('h1C0, 32'hFF);
      chk_pix(2, 40, 7, "R2 non-magic word invalid");
      // R10: unrelated offset ignored
      wr('h1AC, 32'h0010_0011);
      wr('h1C4, 32'hFF);
      wr('h1B0, 32'hB6);
      wr('h1C0, 32'h01);
      chk_pix(2, 40, 7, "R10 other offsets ignored");
      chk_pix(2, 41, 7, "R10 other offsets ignored");

      // R6, R7, R8: full image sweeps at varying levels
      wr('h1BC, 32'hB0);
      for (int i = 0; i < 128; i++) wr('h1C0, 32'((i * 37 + 11) & 'hFF));
      wr('h1BC, 32'hB7);
      for (int i = 0; i < 64; i++) wr('h1C0, 32'(i ^ 'h96));
      sweep(0, "R6 R7 R8 image sweep");
      sweep(3, "R6 R7 R8 image sweep");

      // R8: every level on a set and a clear pixel
      wr('h1BC, 32'hB2);
      wr('h1C0, 32'h01);
      for (int l = 0; l < 8; l++) chk_pix(0, 16, l, "R8 level scaling");
      for (int l = 0; l < 8; l++) chk_pix(0, 17, l, "R7 clear pixel black");

      // R9: store and read of the same byte in one cycle
      wr('h1BC, 32'hB4);
      pix_x = 7'd0; pix_y = 6'd32; level = 3'd7;
      old_exp = exp_rgb(model_pix(0, 32), 7);
      bus_we = 1'b1; bus_addr = 12'h1C0; bus_wdata = 32'hFF;
      @(negedge clk);
      bus_we = 1'b0;
      model_write('h1C0, 32'hFF);
      expect_rgb(old_exp, "R9 same-cycle read sees old byte");
      chk_pix(0, 32, 7, "R9 next read sees new byte");
      chk_pix(0, 32, 4, "R9 level follows one clock");
      chk_pix(5, 33, 6, "R9 coordinate follows one clock");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule